// File: doc/BRIEF.md
# Shared Multi-Writer Blocking Queue Bank

This block holds a set of independent word queues shared by one host and several processor cores. Each core reaches the queues through a register-style access port: it raises a request, says whether it writes or reads, names the queue, and supplies write data. Any number of writers may target the same queue in one cycle. A fixed priority picks one winner, and every other writer is told to hold. A read of an empty queue also holds. The core is expected to keep its request steady while its stall output is high and to retire the access in the cycle the stall drops.

Reads are broadcast. Every core that reads a given queue in a cycle sees the same head word, and that word is removed once. The host has one write port per queue and always outranks the cores. Each queue also reports its occupancy and a flag that compares the occupancy against a threshold, for use by an external event register.

Top module: `mq_fifo_bank`

## Requirements
- R1: After reset every queue reports an occupancy of 0, no stall output is high while no request is present, and with a threshold of 4 every level flag is low.
- R2: Words leave a queue in the order they were accepted, and a queue holds DEPTH (8) words.
- R3: A host write to a queue wins over every core write to that queue in the same cycle, and all of those core writes stall.
- R4: Among cores writing the same queue in a cycle without a host write, the lowest-numbered core is accepted and each higher-numbered one stalls. A stalled writer retries every cycle.
- R5: A write to a full queue (occupancy 8) is refused and stalls, even if the queue is popped in the same cycle. host_wr_stall flags a refused host write, and the occupancy never exceeds 8.
- R6: A core read of an empty queue stalls and removes nothing. A word written in the same cycle is not passed straight through.
- R7: All cores reading one queue in the same cycle receive the same head word, and the occupancy drops by exactly one.
- R8: On a queue that is neither empty nor full, an accepted write and a read in the same cycle both take effect, and the occupancy is unchanged.
- R9: lvl_cnt gives each queue's occupancy in a CW-bit field at index q, and lvl_hit[q] is high exactly when that occupancy is greater than or equal to the field q of lvl_thr.
- R10: Writes by different cores to different queues in one cycle are all accepted with no stall.
- R11: core_stall is high in the same cycle as a blocked request and low in the cycle that request is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | NQ | Host write request, one bit per queue |
| host_wr_data | input | NQ*W | Host write word, field q for queue q |
| host_wr_stall | output | NQ | Host write to queue q refused because it is full |
| core_req | input | NCORE | Core access request |
| core_we | input | NCORE | 1 = write, 0 = read |
| core_sel | input | NCORE*SW | Queue index for each core, field c |
| core_wdata | input | NCORE*W | Core write word, field c |
| core_rdata | output | NCORE*W | Head word of the queue selected by core c |
| core_stall | output | NCORE | Core access blocked this cycle |
| lvl_thr | input | NQ*CW | Level threshold for each queue |
| lvl_cnt | output | NQ*CW | Occupancy of each queue |
| lvl_hit | output | NQ | Occupancy is greater than or equal to the threshold |

## Verification
The bench builds the block with its defaults: four queues of eight 32-bit words and four cores, so SW is 2 and CW is 4. At this size every queue can be filled to capacity and drained word by word within a short run. All four cores can contend for one queue together, so every winner position in the priority chain is observed. Full-queue refusal, empty-queue stalls, broadcast reads and mixed push/pop cycles are each reached on a specific queue, and every expected word is computed from its queue and slot number.

// File: rtl/mq_fifo_bank.sv
module mq_fifo_bank #(
  parameter int NQ    = 4,
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int NCORE = 4,
  localparam int SW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       host_wr_en,
  input  logic [NQ*W-1:0]     host_wr_data,
  output logic [NQ-1:0]       host_wr_stall,
  input  logic [NCORE-1:0]    core_req,
  input  logic [NCORE-1:0]    core_we,
  input  logic [NCORE*SW-1:0] core_sel,
  input  logic [NCORE*W-1:0]  core_wdata,
  output logic [NCORE*W-1:0]  core_rdata,
  output logic [NCORE-1:0]    core_stall,
  input  logic [NQ*CW-1:0]    lvl_thr,
  output logic [NQ*CW-1:0]    lvl_cnt,
  output logic [NQ-1:0]       lvl_hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [W-1:0]  mem   [NQ][DEPTH];
  logic [AW-1:0] rp    [NQ];
  logic [AW-1:0] wp    [NQ];
  logic [CW-1:0] cnt   [NQ];
  logic [W-1:0]  pdata [NQ];
  logic [IW-1:0] wsel  [NQ];
  logic [SW-1:0] sel   [NCORE];
  logic [NQ-1:0] full, empty, push, pop;
  logic [NCORE-1:0] wgrant;

  assign host_wr_stall = host_wr_en & full;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign full[q]  = cnt[q] == CW'(DEPTH);
    assign empty[q] = cnt[q] == '0;
    assign lvl_cnt[q*CW +: CW] = cnt[q];
    assign lvl_hit[q] = cnt[q] >= lvl_thr[q*CW +: CW];

    AST_COUNT_MAX:  assert property (@(posedge clk) disable iff (!rst_n) cnt[q] <= CW'(DEPTH)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full[q] && !pop[q]) |=> full[q]); // R5
    AST_EMPTY_NOPOP: assert property (@(posedge clk) disable iff (!rst_n) empty[q] |=> cnt[q] <= CW'(1)); // R6
    AST_ONE_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                      rst_n |=> (32'(cnt[q]) <= 32'($past(cnt[q])) + 1 && 32'(cnt[q]) + 1 >= 32'($past(cnt[q])))); // R7
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_c
    assign sel[c] = core_sel[c*SW +: SW];
    assign core_rdata[c*W +: W] = mem[sel[c]][rp[sel[c]]];
    assign core_stall[c] = core_req[c] & (core_we[c] ? !wgrant[c] : empty[sel[c]]);

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                      (core_req[c] && core_we[c] && host_wr_en[sel[c]]) |-> core_stall[c]); // R3
    for (genvar h = 0; h < c; h++) begin : g_hi
      AST_LOW_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                      (core_req[c] && core_we[c] && core_req[h] && core_we[h] && sel[c] == sel[h]) |-> core_stall[c]); // R4
    end
  end

  always_comb begin
    logic found;
    for (int q = 0; q < NQ; q++) begin
      found    = 1'b0;
      wsel[q]  = '0;
      pdata[q] = host_wr_data[q*W +: W];
      pop[q]   = 1'b0;
      for (int c = NCORE - 1; c >= 0; c--) begin
        if (core_req[c] && core_we[c] && sel[c] == SW'(q)) begin
          found = 1'b1;
          wsel[q] = IW'(c);
          if (!host_wr_en[q]) pdata[q] = core_wdata[c*W +: W];
        end
        if (core_req[c] && !core_we[c] && sel[c] == SW'(q)) pop[q] = !empty[q];
      end
      push[q] = (host_wr_en[q] || found) && !full[q];
    end
    for (int c = 0; c < NCORE; c++)
      wgrant[c] = core_req[c] && core_we[c] && !host_wr_en[sel[c]] &&
                  push[sel[c]] && wsel[sel[c]] == IW'(c);
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (push[q]) mem[q][wp[q]] <= pdata[q];
      if (!rst_n) begin
        rp[q]  <= '0;
        wp[q]  <= '0;
        cnt[q] <= '0;
      end else begin
        if (push[q]) wp[q] <= (wp[q] == AW'(DEPTH - 1)) ? '0 : wp[q] + 1'b1;
        if (pop[q])  rp[q] <= (rp[q] == AW'(DEPTH - 1)) ? '0 : rp[q] + 1'b1;
        cnt[q] <= cnt[q] + CW'(push[q]) - CW'(pop[q]);
      end
    end
  end
endmodule

// File: tb/test_mq_fifo_bank.sv
module test_mq_fifo_bank;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0]   host_wr_en;
  logic [127:0] host_wr_data;
  logic [3:0]   host_wr_stall;
  logic [3:0]   core_req, core_we;
  logic [7:0]   core_sel;
  logic [127:0] core_wdata, core_rdata;
  logic [3:0]   core_stall;
  logic [15:0]  lvl_thr, lvl_cnt;
  logic [3:0]   lvl_hit;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mq_fifo_bank i_mq_fifo_bank (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_wr_stall(host_wr_stall),
    .core_req(core_req), .core_we(core_we), .core_sel(core_sel),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_stall(core_stall),
    .lvl_thr(lvl_thr), .lvl_cnt(lvl_cnt), .lvl_hit(lvl_hit)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear();
    host_wr_en = '0; host_wr_data = '0;
    core_req = '0; core_we = '0; core_sel = '0; core_wdata = '0;
  endtask

  task automatic cset(input int c, input bit we, input int s, input logic [31:0] d);
    core_req[c] = 1'b1; core_we[c] = we;
    core_sel[c*2 +: 2] = 2'(s); core_wdata[c*32 +: 32] = d;
  endtask

  task automatic hwr(input int q, input logic [31:0] d);
    host_wr_en[q] = 1'b1; host_wr_data[q*32 +: 32] = d;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] cnt(input int q);
    return lvl_cnt[q*4 +: 4];
  endfunction

  function automatic logic [31:0] rd(input int c);
    return core_rdata[c*32 +: 32];
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear();
    lvl_thr = {4{4'd4}};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    for (int q = 0; q < 4; q++) begin
      chk(cnt(q) == 0, "R1 count", 32'(cnt(q)), 0);
      chk(lvl_hit[q] == 0, "R1 flag", 32'(lvl_hit[q]), 0);
    end
    chk(core_stall == 0 && host_wr_stall == 0, "R1 stall", 32'({core_stall, host_wr_stall}), 0);

    cset(0, 0, 2, 0); hwr(2, 32'h77);
    #1 chk(core_stall[0] == 1, "R6 empty read", 32'(core_stall[0]), 1);
    tick();
    clear();
    chk(cnt(2) == 1, "R6 no bypass", 32'(cnt(2)), 1);
    cset(0, 0, 2, 0);
    #1 chk(rd(0) == 32'h77, "R6 later word", rd(0), 32'h77);
    tick(); clear();

    for (int q = 0; q < 4; q++) begin
      for (int i = 0; i < 8; i++) begin
        clear(); hwr(q, 32'hA000_0000 + 32'(q * 16 + i));
        #1 chk(host_wr_stall[q] == 0, "R2 accept", 32'(host_wr_stall[q]), 0);
        tick();
        chk(cnt(q) == 4'(i + 1), "R9 count", 32'(cnt(q)), 32'(i + 1));
        chk(lvl_hit[q] == (i + 1 >= 4), "R9 flag", 32'(lvl_hit[q]), 32'(i + 1 >= 4));
      end
      clear(); hwr(q, 32'hDEAD); cset(1, 1, q, 32'hBEEF);
      #1;
      chk(host_wr_stall[q] == 1, "R5 host full", 32'(host_wr_stall[q]), 1);
      chk(core_stall[1] == 1, "R5 core full", 32'(core_stall[1]), 1);
      tick();
      chk(cnt(q) == 8, "R5 count held", 32'(cnt(q)), 8);
      for (int i = 0; i < 8; i++) begin
        clear(); cset(q, 0, q, 0);
        #1;
        chk(core_stall[q] == 0, "R11 read serviced", 32'(core_stall[q]), 0);
        chk(rd(q) == 32'hA000_0000 + 32'(q * 16 + i), "R2 order", rd(q), 32'hA000_0000 + 32'(q * 16 + i));
        tick();
        chk(cnt(q) == 4'(7 - i), "R2 drain", 32'(cnt(q)), 32'(7 - i));
      end
      clear(); cset(q, 0, q, 0);
      #1 chk(core_stall[q] == 1, "R6 drained", 32'(core_stall[q]), 1);
      tick();
    end

    clear(); hwr(0, 32'h5555_0000); tick();
    clear(); hwr(0, 32'h5555_0001); tick();
    clear();
    for (int c = 0; c < 4; c++) cset(c, 0, 0, 0);
    #1;
    for (int c = 0; c < 4; c++) begin
      chk(rd(c) == 32'h5555_0000, "R7 broadcast", rd(c), 32'h5555_0000);
      chk(core_stall[c] == 0, "R7 no stall", 32'(core_stall[c]), 0);
    end
    tick();
    chk(cnt(0) == 1, "R7 single pop", 32'(cnt(0)), 1);
    clear(); cset(2, 0, 0, 0);
    #1 chk(rd(2) == 32'h5555_0001, "R7 next word", rd(2), 32'h5555_0001);
    tick();

    clear(); hwr(1, 32'hC0DE_0000);
    for (int c = 0; c < 4; c++) cset(c, 1, 1, 32'h100 + 32'(c));
    #1 chk(core_stall == 4'hF, "R3 host wins", 32'(core_stall), 32'hF);
    tick();
    host_wr_en = '0;
    for (int w = 0; w < 4; w++) begin
      #1;
      for (int c = 0; c < 4; c++)
        chk(core_stall[c] == (c > w), "R4 priority", 32'(core_stall[c]), 32'(c > w));
      tick();
      core_req[w] = 1'b0;
    end
    chk(cnt(1) == 5, "R4 count", 32'(cnt(1)), 5);
    for (int i = 0; i < 5; i++) begin
      clear(); cset(0, 0, 1, 0);
      #1 chk(rd(0) == ((i == 0) ? 32'hC0DE_0000 : 32'h100 + 32'(i - 1)), "R4 order",
             rd(0), (i == 0) ? 32'hC0DE_0000 : 32'h100 + 32'(i - 1));
      tick();
    end

    for (int i = 0; i < 3; i++) begin
      clear(); hwr(2, 32'h30 + 32'(i)); tick();
    end
    clear(); cset(0, 1, 2, 32'h33); cset(1, 0, 2, 0);
    #1;
    chk(core_stall[1:0] == 0, "R8 both serviced", 32'(core_stall[1:0]), 0);
    chk(rd(1) == 32'h30, "R8 head", rd(1), 32'h30);
    tick();
    chk(cnt(2) == 3, "R8 count", 32'(cnt(2)), 3);

    for (int i = 0; i < 8; i++) begin
      clear(); hwr(3, 32'h40 + 32'(i)); tick();
    end
    clear(); cset(0, 0, 3, 0); cset(1, 1, 3, 32'h99);
    #1;
    chk(core_stall[1] == 1 && core_stall[0] == 0, "R5 full with pop", 32'(core_stall[1:0]), 2);
    tick();
    chk(cnt(3) == 7, "R5 pop only", 32'(cnt(3)), 7);

    clear();
    for (int c = 0; c < 4; c++) cset(c, 1, c, 32'h200 + 32'(c));
    #1 chk(core_stall == 0, "R10 parallel", 32'(core_stall), 0);
    tick(); clear();
    chk(lvl_cnt == {4'd8, 4'd4, 4'd1, 4'd1}, "R10 counts", 32'(lvl_cnt), 32'h8411);

    lvl_thr = {4'd8, 4'd0, 4'd5, 4'd2};
    #1 chk(lvl_hit == 4'b1100, "R9 thresholds", 32'(lvl_hit), 32'hC);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule